// File: doc/BRIEF.md
# Interrupt Request Trigger Selector

This block is the request-capture front end of one eight-input interrupt controller. Every raw request line first crosses a two-flop synchroniser. The block then decides, channel by channel, whether a request counts on a rising transition or simply while the line is high. It reports the result as a pending vector. One copy sits in front of each controller of a cascade. Priority resolution, masking and vector generation happen downstream.

The trigger type of a channel comes from one of two places. Each channel has its own mode bit in `chan_level`. The controller also has one shared bit, `global_level`. A software select bit, `use_per_chan`, picks the source. When it is low, the shared bit alone sets the type of every channel, which gives the classic controller-wide behaviour.

Each pending bit is cleared by a one-cycle acknowledge pulse on its own channel, or by reset. A source must hold its line high until it is acknowledged. A request that is withdrawn before that point is dropped.

Top module: `irq_trigger_front`

## Requirements
- R1: While `rst_n` is low, `pend` is all zeros and the synchroniser and edge history are cleared.
- R2: The effective mode of channel i is `chan_level[i]` when `use_per_chan` is 1, and `global_level` when it is 0. In both cases the value 1 means level mode and 0 means edge mode.
- R3: A change on `irq_raw` reaches `pend` at the third rising clock edge after it is sampled. It is not visible at the second.
- R4: In edge mode, a 0-to-1 transition of the synchronised input sets the pending bit. The bit then stays set while the input stays high.
- R5: In edge mode, an acknowledge clears the pending bit. The bit does not set again while the input stays high.
- R6: In edge mode, the pending bit clears when the synchronised input falls, even without an acknowledge.
- R7: In level mode, the pending bit is 1 exactly while the synchronised input is high.
- R8: In level mode, an acknowledge clears the pending bit for one cycle. If the input is still high, the bit is set again on the following edge.
- R9: If an acknowledge falls in the same cycle as a newly detected edge, the acknowledge wins. The edge is discarded and does not set the pending bit later.
- R10: When a channel's effective mode changes, its edge history is reloaded with the present input. Entering edge mode clears the pending bit, and an input already held high does not count as a new edge. Entering level mode with the input high sets the pending bit.
- R11: An acknowledge on one channel leaves every other channel's pending bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_raw | input | 8 | Asynchronous request lines, one per channel |
| chan_level | input | 8 | Per-channel mode bits (1 = level, 0 = edge) |
| global_level | input | 1 | Controller-wide mode bit (1 = level, 0 = edge) |
| use_per_chan | input | 1 | 1 selects `chan_level`, 0 selects `global_level` |
| ack | input | 8 | One-cycle acknowledge pulse per channel |
| pend | output | 8 | Pending request vector |

## Verification
Two functions can land on the same cycle: an acknowledge, and the first edge at which the synchronised input is high. The bench provokes this by driving `ack` two cycles after it raises `irq_raw`, which puts both at the same rising edge. It does this for every combination of select bit, global bit and four per-channel patterns. The expected result is that `pend` stays low in that cycle. Afterwards, only the channels computed to be in level mode come back high, and the edge channels stay low because their edge was consumed.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;

   typedef enum logic {
      TRIG_EDGE  = 1'b0,
      TRIG_LEVEL = 1'b1
   } trig_e;

   localparam int unsigned MIN_SYNC = 2;

endpackage

// File: rtl/irq_sync_chain.sv
module irq_sync_chain #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q_out
);

   logic [WIDTH-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q_out = stg[STAGES-1];

endmodule

// File: rtl/irq_mode_sel.sv
module irq_mode_sel #(
   parameter int unsigned NCH = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] chan_level,
   input  logic           global_level,
   input  logic           use_per_chan,
   output logic [NCH-1:0] eff_level,
   output logic [NCH-1:0] mode_flip
);

   logic [NCH-1:0] eff_q;

   // Source of each channel's trigger type.
   assign eff_level = use_per_chan ? chan_level : {NCH{global_level}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) eff_q <= '0;
      else        eff_q <= eff_level;
   end

   assign mode_flip = eff_level ^ eff_q;

endmodule

// File: rtl/irq_capture_cell.sv
module irq_capture_cell
   import irq_trig_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_s,
   input  logic lvl_mode,
   input  logic flip,
   input  logic ack,
   output logic pend
);

   logic  hist;
   trig_e mode;

   assign mode = trig_e'(lvl_mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist <= 1'b0;
         pend <= 1'b0;
      end else begin
         // History always reloads with the present input; on a mode
         // flip this discards the old history so no edge is invented.
         hist <= req_s;
         unique case (mode)
            TRIG_LEVEL: pend <= req_s & ~ack;
            TRIG_EDGE: begin
               if (ack || !req_s || flip) pend <= 1'b0;
               else if (!hist)            pend <= 1'b1;
            end
            default: pend <= 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/irq_trigger_front.sv
module irq_trigger_front
   import irq_trig_pkg::*;
#(
   parameter int unsigned NCH         = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] irq_raw,
   input  logic [NCH-1:0] chan_level,
   input  logic           global_level,
   input  logic           use_per_chan,
   input  logic [NCH-1:0] ack,
   output logic [NCH-1:0] pend
);

   generate
      if (NCH < 1 || NCH > 32) begin : g_bad_nch
         $error("irq_trigger_front: NCH must be 1..32");
      end
      if (SYNC_STAGES < MIN_SYNC) begin : g_bad_sync
         $error("irq_trigger_front: SYNC_STAGES below minimum");
      end
   endgenerate

   logic [NCH-1:0] req_s;
   logic [NCH-1:0] eff_level;
   logic [NCH-1:0] mode_flip;

   irq_sync_chain #(
      .WIDTH (NCH),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_in (irq_raw),
      .q_out(req_s)
   );

   irq_mode_sel #(
      .NCH(NCH)
   ) u_mode (
      .clk         (clk),
      .rst_n       (rst_n),
      .chan_level  (chan_level),
      .global_level(global_level),
      .use_per_chan(use_per_chan),
      .eff_level   (eff_level),
      .mode_flip   (mode_flip)
   );

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_cell
         irq_capture_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_s   (req_s[i]),
            .lvl_mode(eff_level[i]),
            .flip    (mode_flip[i]),
            .ack     (ack[i]),
            .pend    (pend[i])
         );
      end
   endgenerate

endmodule

// File: rtl/irq_trigger_front_chk.sv
module irq_trigger_front_chk #(
   parameter int unsigned NCH = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NCH-1:0] irq_raw,
   input logic [NCH-1:0] chan_level,
   input logic           global_level,
   input logic           use_per_chan,
   input logic [NCH-1:0] ack,
   input logic [NCH-1:0] pend
);

   logic [2:0]     since_rst;
   logic [NCH-1:0] eff;

   assign eff = use_per_chan ? chan_level : {NCH{global_level}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              since_rst <= '0;
      else if (since_rst != 3'd6) since_rst <= since_rst + 3'd1;
   end

   // R1
   always @(negedge clk) begin
      if (rst_n === 1'b0) begin
         reset_clear_chk: assert (pend == '0);
      end
   end

   // R5
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack != '0) |=> ((pend & $past(ack)) == '0));

   // R7
   pend_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 3'd5) |-> ((pend & ~$past(irq_raw, 3)) == '0));

   // R10
   edge_needs_low_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 3'd6) |->
      (((pend & ~$past(pend)) & ~$past(eff) & $past(irq_raw, 4)) == '0));

endmodule

bind irq_trigger_front irq_trigger_front_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/irq_trigger_front_tb.sv
module irq_trigger_front_tb;

   localparam int  CLK_PERIOD = 10;
   localparam int  NCH        = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] irq_raw = '0;
   logic [NCH-1:0] chan_level = '0;
   logic           global_level = 1'b0;
   logic           use_per_chan = 1'b0;
   logic [NCH-1:0] ack = '0;
   logic [NCH-1:0] pend;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_trigger_front #(.NCH(NCH)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_raw     (irq_raw),
      .chan_level  (chan_level),
      .global_level(global_level),
      .use_per_chan(use_per_chan),
      .ack         (ack),
      .pend        (pend)
   );

   task automatic tick(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [NCH-1:0] exp);
      n_chk++;
      if (pend !== exp) begin
         n_fail++;
         $display("FAIL %s: pend=%h expected=%h", req, pend, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: pend=%h expected=done", pend);
      finish_run();
   end

   initial begin
      logic [NCH-1:0] pats [4];
      logic [NCH-1:0] lm;
      pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h3C;

      // R1: reset holds pend low even with requests raised
      irq_raw = '1;
      tick(4);
      check("R1", '0);
      irq_raw = '0;
      tick(1);
      rst_n = 1'b1;
      tick(4);
      check("R1", '0);

      // Sweep over select bit, global bit and per-channel patterns
      for (int sel = 0; sel < 2; sel++) begin
         for (int g = 0; g < 2; g++) begin
            for (int p = 0; p < 4; p++) begin
               use_per_chan = sel[0];
               global_level = g[0];
               chan_level   = pats[p];
               lm = sel[0] ? pats[p] : {NCH{g[0]}};   // R2
               irq_raw = '0;
               tick(4);
               check("R2", '0);
               // R3: not visible after two edges, visible after three
               irq_raw = '1;
               tick(2);
               check("R3", '0);
               tick(1);
               check("R4", '1);                       // R4 / R7
               // R5 / R8: acknowledge with input still high
               ack = '1;
               tick(1);
               ack = '0;
               check("R5", '0);
               tick(1);
               check("R8", lm);
               tick(2);
               check("R5", lm);
               // R7: level follows drop, edge already clear
               irq_raw = '0;
               tick(2);
               check("R7", lm);
               tick(1);
               check("R7", '0);
               tick(2);
               // R9: acknowledge lands on the first detecting edge
               irq_raw = '1;
               tick(2);
               ack = '1;
               tick(1);
               ack = '0;
               check("R9", '0);
               tick(1);
               check("R9", lm);
               tick(2);
               check("R9", lm);
               // R6: withdrawn request before acknowledge
               irq_raw = '0;
               tick(3);
               irq_raw = '1;
               tick(3);
               check("R6", '1);
               irq_raw = '0;
               tick(3);
               check("R6", '0);
            end
         end
      end

      // R11: single-channel acknowledge in edge mode
      use_per_chan = 1'b0;
      global_level = 1'b0;
      irq_raw = '0;
      tick(4);
      irq_raw = '1;
      tick(3);
      check("R11", '1);
      ack = 8'h01;
      tick(1);
      ack = '0;
      check("R11", 8'hFE);
      ack = 8'h80;
      tick(1);
      ack = '0;
      check("R11", 8'h7E);

      // R10: level -> edge with input held high, then back to level
      irq_raw = '0;
      tick(3);
      global_level = 1'b1;
      irq_raw = '1;
      tick(4);
      check("R10", '1);
      global_level = 1'b0;
      tick(1);
      check("R10", '0);
      tick(3);
      check("R10", '0);
      global_level = 1'b1;
      tick(1);
      check("R10", '1);
      // R10 with per-channel switching of only half the channels
      use_per_chan = 1'b1;
      chan_level   = 8'hFF;
      tick(2);
      chan_level   = 8'h0F;
      tick(3);
      check("R10", 8'h0F);

      finish_run();
   end

endmodule